// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block holds a set of alarm field registers (second, minute, hour, day, month and year) and one alarm control register. Software loads them through a simple write port. Once per second a timekeeping block advances the calendar and pulses a strobe. In that cycle this block compares the enabled alarm fields against the BCD time presented on its inputs. When every enabled field matches, it sets a sticky pending flag, which drives a level interrupt line.

Each field has its own compare-enable bit, and a separate master enable gates the whole comparison. Values written to the field registers are cut down to the width that the field's BCD range needs. The year is compared as a three-digit BCD value. Software acknowledges the interrupt by writing a one to the pending bit.

Top module: `rtc_alarm_match`

## Requirements
- R1: Control bits 0..5 enable the compare of second, minute, hour, day, month and year in that order. A field whose enable bit is clear takes no part in the match.
- R2: Control bit 6 is the master enable. While it is 0 no alarm is raised, whatever the field bits and time values are.
- R3: The compare happens only in a cycle where `sec_tick` is 1, and it uses the time inputs of that cycle. The pending flag rises on the clock edge that ends that cycle.
- R4: Writes keep only the low bits of `wr_data` that each field needs: 7 for second and minute, 6 for hour and day, 5 for month, 12 for year. The compare uses the kept bits, zero-extended to the input width.
- R5: The year compare uses all 12 bits, so the hundreds digit in bits 11:8 must match as well.
- R6: A hit sets `alarm_pend` and `alarm_irq` together. Both stay high until they are cleared.
- R7: A write to address 7 with `wr_data[1]`=1 clears the flag and drops the interrupt. With `wr_data[1]`=0 the write has no effect on the flag.
- R8: An alarm needs every enabled field to match. With the master enable set and no field bit set, no alarm occurs.
- R9: When a hit and a clear write fall in the same cycle, the flag ends that cycle set.
- R10: Synchronous active-high reset zeroes the control register, all field registers and the flag.
- R11: Write addresses: 0 is the control register, 1 to 6 are second, minute, hour, day, month and year, and 7 is the pending clear. A write takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register select |
| wr_data | input | 12 | Write data |
| sec_tick | input | 1 | One-cycle pulse after each time advance |
| now_sec | input | 8 | Current second, BCD |
| now_min | input | 8 | Current minute, BCD |
| now_hour | input | 8 | Current hour, BCD |
| now_day | input | 8 | Current day of month, BCD |
| now_mon | input | 8 | Current month, BCD |
| now_year | input | 12 | Current year, three BCD digits |
| alarm_irq | output | 1 | Level alarm interrupt |
| alarm_pend | output | 1 | Alarm pending flag |

## Verification
The assertions check four rules on every cycle. The flag cannot rise without a strobe, without the master enable, or with an empty field mask. A clear removes the flag unless a hit arrives in the same cycle, and a hit always wins over a clear. Only the bench scenarios can show that the field values match correctly. Those scenarios cover the width masking, the role of the hundreds digit of the year, the way the per-field mask selects which mismatches matter, and that reset zeroes the stored fields.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_FLD  = 6;
  localparam int DATA_W   = 12;
  localparam int ADDR_W   = 3;
  localparam int CTRL_W   = NUM_FLD + 1;
  localparam int GLB_BIT  = NUM_FLD;
  localparam int PEND_BIT = 1;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_PEND = 3'd7;
  // stored width per field: sec, min, hour, day, month, year
  localparam int FLD_W [NUM_FLD] = '{7, 7, 6, 6, 5, 12};
endpackage

// File: rtl/alarm_field.sv
module alarm_field #(
  parameter int W     = 7,
  parameter int CMP_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic [CMP_W-1:0] now,
  output logic             hit
);
  logic [W-1:0] stored_q;

  always_ff @(posedge clk) begin
    if (rst)        stored_q <= '0;
    else if (wr_en) stored_q <= wr_data;
  end

  assign hit = (now == CMP_W'(stored_q));

  AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (stored_q == $past(wr_data))); // R4
endmodule

// File: rtl/alarm_pending.sv
module alarm_pending (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic pend
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst)      pend_q <= 1'b0;
    else if (set) pend_q <= 1'b1;
    else if (clr) pend_q <= 1'b0;
  end

  assign pend = pend_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set |=> pend_q); // R9
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !pend_q); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clr) |=> pend_q); // R6
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sec_tick,
  input  logic [7:0]        now_sec,
  input  logic [7:0]        now_min,
  input  logic [7:0]        now_hour,
  input  logic [7:0]        now_day,
  input  logic [7:0]        now_mon,
  input  logic [11:0]       now_year,
  output logic              alarm_irq,
  output logic              alarm_pend
);
  logic [CTRL_W-1:0]  ctrl_q;
  logic [DATA_W-1:0]  now_arr [NUM_FLD];
  logic [NUM_FLD-1:0] hit;
  logic [NUM_FLD-1:0] fld_en;
  logic               glb_en;
  logic               fire;
  logic               clr;
  logic               pend_q;

  always_ff @(posedge clk) begin
    if (rst)                                ctrl_q <= '0;
    else if (wr_en && wr_addr == ADR_CTRL)  ctrl_q <= wr_data[CTRL_W-1:0];
  end

  assign now_arr[0] = DATA_W'(now_sec);
  assign now_arr[1] = DATA_W'(now_min);
  assign now_arr[2] = DATA_W'(now_hour);
  assign now_arr[3] = DATA_W'(now_day);
  assign now_arr[4] = DATA_W'(now_mon);
  assign now_arr[5] = DATA_W'(now_year);

  for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
    localparam int W = FLD_W[g];
    alarm_field #(.W(W), .CMP_W(DATA_W)) u_fld (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en && (wr_addr == ADDR_W'(g + 1))),
      .wr_data (wr_data[W-1:0]),
      .now     (now_arr[g]),
      .hit     (hit[g])
    );
  end

  assign fld_en = ctrl_q[NUM_FLD-1:0];
  assign glb_en = ctrl_q[GLB_BIT];
  assign fire   = sec_tick && glb_en && (|fld_en) && (&(hit | ~fld_en));
  assign clr    = wr_en && (wr_addr == ADR_PEND) && wr_data[PEND_BIT];

  alarm_pending u_pend (
    .clk  (clk),
    .rst  (rst),
    .set  (fire),
    .clr  (clr),
    .pend (pend_q)
  );

  assign alarm_pend = pend_q;
  assign alarm_irq  = pend_q;

  AST_NO_TICK_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (!sec_tick && !alarm_pend) |=> !alarm_pend); // R3
  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (rst)
    (!glb_en && !alarm_pend) |=> !alarm_pend); // R2
  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (rst)
    ((fld_en == '0) && !alarm_pend) |=> !alarm_pend); // R8
endmodule

// File: tb/test_rtc_alarm_match.sv
`timescale 1ns/1ps
module test_rtc_alarm_match;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic sec_tick = 1'b0;
  logic [7:0] now_sec = 8'h45, now_min = 8'h30, now_hour = 8'h12;
  logic [7:0] now_day = 8'h15, now_mon = 8'h06;
  logic [11:0] now_year = 12'h024;
  logic alarm_irq, alarm_pend;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_alarm_match i_rtc_alarm_match (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .sec_tick,
    .now_sec, .now_min, .now_hour, .now_day, .now_mon, .now_year,
    .alarm_irq, .alarm_pend
  );

  typedef struct packed {
    logic [6:0]  ctrl;
    logic [11:0] a_sec, a_min, a_hour, a_day, a_mon, a_year;
    logic        exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{7'h41, 12'h045, 12'h030, 12'h012, 12'h015, 12'h006, 12'h024, 1'b1}, // R1 R6
    '{7'h41, 12'h044, 12'h030, 12'h012, 12'h015, 12'h006, 12'h024, 1'b0}, // R1
    '{7'h01, 12'h045, 12'h030, 12'h012, 12'h015, 12'h006, 12'h024, 1'b0}, // R2
    '{7'h7F, 12'h045, 12'h030, 12'h012, 12'h015, 12'h006, 12'h024, 1'b1}, // R8 all
    '{7'h7F, 12'h045, 12'h031, 12'h012, 12'h015, 12'h006, 12'h024, 1'b0}, // R8
    '{7'h40, 12'h045, 12'h030, 12'h012, 12'h015, 12'h006, 12'h024, 1'b0}, // R8 empty
    '{7'h5D, 12'h045, 12'h031, 12'h012, 12'h015, 12'h006, 12'h024, 1'b1}, // R1 masked off
    '{7'h41, 12'h0C5, 12'h030, 12'h012, 12'h015, 12'h006, 12'h024, 1'b1}, // R4 sec
    '{7'h44, 12'h045, 12'h030, 12'h0D2, 12'h015, 12'h006, 12'h024, 1'b1}, // R4 hour
    '{7'h50, 12'h045, 12'h030, 12'h012, 12'h015, 12'h0E6, 12'h024, 1'b1}, // R4 month
    '{7'h60, 12'h045, 12'h030, 12'h012, 12'h015, 12'h006, 12'h024, 1'b1}, // R5
    '{7'h60, 12'h045, 12'h030, 12'h012, 12'h015, 12'h006, 12'h124, 1'b0}, // R5 hundreds
    '{7'h48, 12'h045, 12'h030, 12'h012, 12'h0D5, 12'h006, 12'h024, 1'b1}, // R4 day
    '{7'h42, 12'h045, 12'h0B0, 12'h012, 12'h015, 12'h006, 12'h024, 1'b1}  // R4 minute
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_pend(input string req, input bit exp);
    check(alarm_pend == exp && alarm_irq == exp, req, {alarm_irq, alarm_pend}, {exp, exp});
  endtask

  task automatic wr(input logic [2:0] a, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_pend("R10 reset state", 1'b0);

    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 12'(VEC[i].ctrl));
      wr(3'd1, VEC[i].a_sec);
      wr(3'd2, VEC[i].a_min);
      wr(3'd3, VEC[i].a_hour);
      wr(3'd4, VEC[i].a_day);
      wr(3'd5, VEC[i].a_mon);
      wr(3'd6, VEC[i].a_year);
      wr(3'd7, 12'h002);
      tick();
      chk_pend($sformatf("R1/R2/R4/R5/R6/R8 vector %0d", i), VEC[i].exp);
    end

    // R3: configured match, no strobe -> nothing
    wr(3'd7, 12'h002);
    wr(3'd0, 12'h041); wr(3'd1, 12'h045);
    repeat (5) @(negedge clk);
    chk_pend("R3 no strobe", 1'b0);
    // R3: time at strobe differs -> no hit
    now_sec = 8'h46;
    tick();
    chk_pend("R3 time at strobe", 1'b0);
    now_sec = 8'h45;
    tick();
    chk_pend("R3 strobe hit", 1'b1);

    // R7: bit1=0 write has no effect, bit1=1 clears
    wr(3'd7, 12'hFFD);
    chk_pend("R7 zero bit keeps", 1'b1);
    wr(3'd7, 12'h002);
    chk_pend("R7 clear", 1'b0);

    // R9: hit and clear in same cycle
    tick();
    @(negedge clk);
    sec_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd7; wr_data = 12'h002;
    @(negedge clk);
    sec_tick = 1'b0; wr_en = 1'b0;
    chk_pend("R9 set beats clear", 1'b1);

    // R11: write to ctrl takes effect on next edge (disable master)
    wr(3'd7, 12'h002);
    wr(3'd0, 12'h001);
    tick();
    chk_pend("R11 ctrl write", 1'b0);

    // R10: reset clears fields and flag
    wr(3'd0, 12'h041);
    tick();
    chk_pend("R10 pre-reset set", 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk_pend("R10 flag cleared", 1'b0);
    wr(3'd0, 12'h041);
    now_sec = 8'h00;
    tick();
    chk_pend("R10 field zeroed", 1'b1);
    wr(3'd0, 12'h000);
    wr(3'd7, 12'h002);
    tick();
    chk_pend("R10 ctrl path quiet", 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule